// File: doc/BRIEF.md
# DRAM Auto-Refresh Sequencer

This block keeps one group of DRAM ranks refreshed. A free-running interval timer raises a refresh-due event every `INTERVAL` clock cycles. The due times sit on a fixed grid measured from reset, so they do not drift when a refresh is delayed or runs long. When a refresh falls due, the sequencer blocks new accesses to the array and waits until the accesses already in flight have finished. If any bank still holds an open row, it asks for a precharge of all banks and waits for the acknowledge. It then issues a one-cycle refresh command and keeps the array reserved for `RFC_CYCLES` cycles before returning to normal operation.

The sequencer has four named states. In **Idle** (code 0) accesses run normally. In **Drain** (code 1) new accesses are blocked and rows may stay open while outstanding accesses complete. In **Precharge** (code 2) the precharge-all request is held. In **Run** (code 3) the refresh cycle time is counted. The named transitions are as follows. *start*: Idle to Drain when a refresh is due or owed. *drained-open*: Drain to Precharge when nothing is outstanding and a bank is open. *drained-closed*: Drain to Run when nothing is outstanding and no bank is open. *precharged*: Precharge to Run on the acknowledge. *done*: Run to Idle when the refresh cycle time has elapsed. A due event that arrives while a refresh is still under way is remembered. The *start* transition then fires on the first cycle back in Idle.

Top module: `refresh_sequencer`

## Requirements
- R1: While reset is asserted, state_code is 0 and block_access, prech_all_req and ref_cmd are all 0.
- R2: state_code reports Idle as 0, Drain as 1, Precharge as 2 and Run as 3.
- R3: With the sequencer idle, the state changes from 0 to 1 on the rising edge that ends the INTERVAL-th cycle after reset release, and not before.
- R4: In Drain, the state stays 1 on every rising edge at which acc_busy is 1.
- R5: In Drain, on the first rising edge with acc_busy at 0, the state goes to 2 if bank_open is 1 and goes directly to 3 if bank_open is 0.
- R6: prech_all_req is 1 exactly while the state is 2. The state stays 2 until a rising edge sees prech_ack at 1, and then it goes to 3.
- R7: ref_cmd is 1 for exactly the first cycle of state 3. State 3 lasts RFC_CYCLES cycles, and the sequencer then returns to state 0.
- R8: block_access is 1 in states 1, 2 and 3, and 0 in state 0.
- R9: The n-th due event occurs n*INTERVAL cycles after reset release, whatever the length of earlier refreshes. A due event that arrives while the sequencer is not idle makes it enter state 1 on the cycle after it returns to state 0.
- R10: acc_busy and prech_ack have no effect in state 0, and prech_ack has no effect in state 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_busy | input | 1 | High while any access to the array is still outstanding |
| bank_open | input | 1 | High while at least one bank has an open row |
| prech_ack | input | 1 | Precharge-all completion acknowledge |
| block_access | output | 1 | Stops the scheduler from issuing new accesses |
| prech_all_req | output | 1 | Request to precharge every bank |
| ref_cmd | output | 1 | One-cycle refresh command strobe |
| state_code | output | 2 | Current sequencer state (0 Idle, 1 Drain, 2 Precharge, 3 Run) |

## Verification
Every state change is registered, so state_code, block_access and prech_all_req respond to an input on the rising edge after the cycle in which the input is seen. ref_cmd comes from its own register that is loaded by the same transition, so it rises together with state 3. The first due event lands exactly INTERVAL edges after reset release, and later ones land on multiples of INTERVAL. The bench changes inputs on falling edges and counts rising edges from reset release. It samples one falling edge after each rising edge, so every expected value is tied to a known edge number and never to process ordering.

// File: rtl/refseq_pkg.sv
package refseq_pkg;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_DRAIN = 2'd1,
        RS_PRECH = 2'd2,
        RS_RUN   = 2'd3
    } rs_state_e;

endpackage

// File: rtl/refseq_interval_timer.sv
module refseq_interval_timer #(
    parameter int INTERVAL = 780
) (
    input  logic clk,
    input  logic rst_n,
    output logic due_tick
);
    localparam int CW = $clog2(INTERVAL + 1);
    localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt_q;

    // Free-running: reload is independent of refresh progress, so no drift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RELOAD;
        end else if (cnt_q == '0) begin
            cnt_q <= RELOAD;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign due_tick = (cnt_q == '0);

    // R9: due events are spaced, never back to back
    assert_due_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        due_tick |=> !due_tick);

endmodule

// File: rtl/refseq_run_timer.sv
module refseq_run_timer #(
    parameter int RFC_CYCLES = 26
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic active,
    output logic done
);
    localparam int CW = $clog2(RFC_CYCLES + 1);
    localparam logic [CW-1:0] START = CW'(RFC_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= START;
        end else if (active && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

    // R7: a load never completes in the same cycle it is issued
    assert_load_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (RFC_CYCLES == 1) || !done);

endmodule

// File: rtl/refseq_fsm.sv
module refseq_fsm
    import refseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      due_tick,
    input  logic      run_done,
    input  logic      acc_busy,
    input  logic      bank_open,
    input  logic      prech_ack,
    output rs_state_e state_q,
    output logic      run_load,
    output logic      block_access,
    output logic      prech_all_req,
    output logic      ref_cmd
);
    rs_state_e state_d;
    logic      owed_q;
    logic      cmd_q;
    logic      start;

    assign start = (state_q == RS_IDLE) && (due_tick || owed_q);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and run-entry decode
    always_comb begin
        state_d  = state_q;
        run_load = 1'b0;
        unique case (state_q)
            RS_IDLE: begin
                if (start) state_d = RS_DRAIN;
            end
            RS_DRAIN: begin
                if (!acc_busy) begin
                    if (bank_open) begin
                        state_d = RS_PRECH;
                    end else begin
                        state_d  = RS_RUN;
                        run_load = 1'b1;
                    end
                end
            end
            RS_PRECH: begin
                if (prech_ack) begin
                    state_d  = RS_RUN;
                    run_load = 1'b1;
                end
            end
            RS_RUN: begin
                if (run_done) state_d = RS_IDLE;
            end
            default: state_d = RS_IDLE;
        endcase
    end

    // Owed refresh and command strobe registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed_q <= 1'b0;
            cmd_q  <= 1'b0;
        end else begin
            owed_q <= (owed_q || due_tick) && !start;
            cmd_q  <= run_load;
        end
    end

    // Outputs
    always_comb begin
        block_access  = 1'b1;
        prech_all_req = 1'b0;
        unique case (state_q)
            RS_IDLE:  block_access  = 1'b0;
            RS_DRAIN: prech_all_req = 1'b0;
            RS_PRECH: prech_all_req = 1'b1;
            RS_RUN:   prech_all_req = 1'b0;
            default:  block_access  = 1'b1;
        endcase
        ref_cmd = cmd_q;
    end

    assert_drain_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_DRAIN && acc_busy) |=> state_q == RS_DRAIN);

    assert_drain_to_prech_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_DRAIN && !acc_busy && bank_open) |=> state_q == RS_PRECH);

    assert_prech_waits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_PRECH && !prech_ack) |=> (state_q == RS_PRECH && prech_all_req));

    assert_cmd_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd |=> !ref_cmd);

    assert_cmd_in_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd |-> state_q == RS_RUN);

    assert_run_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_RUN && run_done) |=> state_q == RS_IDLE);

    assert_idle_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_IDLE && due_tick) |=> state_q == RS_DRAIN);

endmodule

// File: rtl/refresh_sequencer.sv
module refresh_sequencer
    import refseq_pkg::*;
#(
    parameter int INTERVAL   = 780,
    parameter int RFC_CYCLES = 26
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_busy,
    input  logic       bank_open,
    input  logic       prech_ack,
    output logic       block_access,
    output logic       prech_all_req,
    output logic       ref_cmd,
    output logic [1:0] state_code
);
    logic      due_tick;
    logic      run_load;
    logic      run_done;
    rs_state_e state_q;

    refseq_interval_timer #(.INTERVAL(INTERVAL)) u_interval (
        .clk      (clk),
        .rst_n    (rst_n),
        .due_tick (due_tick)
    );

    refseq_run_timer #(.RFC_CYCLES(RFC_CYCLES)) u_run (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (run_load),
        .active (state_q == RS_RUN),
        .done   (run_done)
    );

    refseq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .due_tick      (due_tick),
        .run_done      (run_done),
        .acc_busy      (acc_busy),
        .bank_open     (bank_open),
        .prech_ack     (prech_ack),
        .state_q       (state_q),
        .run_load      (run_load),
        .block_access  (block_access),
        .prech_all_req (prech_all_req),
        .ref_cmd       (ref_cmd)
    );

    assign state_code = state_q;

    // R8: accesses are blocked whenever a refresh is in progress
    assert_block_nonidle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code != 2'd0) |-> block_access);

endmodule

// File: tb/refresh_sequencer_test.sv
module refresh_sequencer_test;
    localparam int IVL = 40;
    localparam int RFC = 5;
    localparam int NROWS = 5;
    // columns: drain busy cycles, bank_open, cycles before prech_ack
    localparam int TBL [NROWS][3] = '{
        '{0, 1, 0},
        '{3, 0, 0},
        '{2, 1, 3},
        '{5, 1, 1},
        '{1, 0, 0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_busy = 1'b0;
    logic       bank_open = 1'b0;
    logic       prech_ack = 1'b0;
    logic       block_access;
    logic       prech_all_req;
    logic       ref_cmd;
    logic [1:0] state_code;

    int tests = 0;
    int fails = 0;
    int e = 0;

    always #5 clk = ~clk;

    refresh_sequencer #(.INTERVAL(IVL), .RFC_CYCLES(RFC)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .acc_busy      (acc_busy),
        .bank_open     (bank_open),
        .prech_ack     (prech_ack),
        .block_access  (block_access),
        .prech_all_req (prech_all_req),
        .ref_cmd       (ref_cmd),
        .state_code    (state_code)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at edge %0d: actual %0d expected %0d", req, e, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        e++;
    endtask

    task automatic run_to(input int target);
        while (e < target) step();
    endtask

    task automatic do_round(input int busy_len, input int open, input int ack_len, input int due);
        int run_entry;
        acc_busy  = 1'b1;
        bank_open = open[0];
        prech_ack = 1'b1;
        run_to(due - 1);
        chk("R3 idle before due", state_code, 0);
        chk("R8 unblocked in idle", block_access, 0);
        chk("R10 ack ignored in idle", prech_all_req, 0);
        step();
        chk("R3 drain at due", state_code, 1);
        chk("R8 blocked in drain", block_access, 1);
        for (int i = 0; i < busy_len; i++) begin
            step();
            chk("R4 drain while busy", state_code, 1);
            chk("R10 ack ignored in drain", prech_all_req, 0);
        end
        acc_busy  = 1'b0;
        prech_ack = 1'b0;
        step();
        if (open != 0) begin
            chk("R5 open goes to precharge", state_code, 2);
            chk("R6 request in precharge", prech_all_req, 1);
            chk("R8 blocked in precharge", block_access, 1);
            for (int i = 0; i < ack_len; i++) begin
                step();
                chk("R6 waits for ack", state_code, 2);
            end
            prech_ack = 1'b1;
            step();
            prech_ack = 1'b0;
        end else begin
            chk("R5 closed skips precharge", state_code, 3);
        end
        run_entry = e;
        chk("R2 run code", state_code, 3);
        chk("R6 request dropped", prech_all_req, 0);
        chk("R7 command pulse", ref_cmd, 1);
        step();
        chk("R7 command one cycle", ref_cmd, 0);
        chk("R8 blocked in run", block_access, 1);
        run_to(run_entry + RFC - 1);
        chk("R7 run length", state_code, 3);
        step();
        chk("R7 back to idle", state_code, 0);
        chk("R8 unblocked after run", block_access, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset state", state_code, 0);
        chk("R1 reset block", block_access, 0);
        chk("R1 reset request", prech_all_req, 0);
        chk("R1 reset command", ref_cmd, 0);
        rst_n = 1'b1;
        e = 0;

        for (int r = 0; r < NROWS; r++) begin
            do_round(TBL[r][0], TBL[r][1], TBL[r][2], (r + 1) * IVL);
        end

        // R9: owed refresh when a due event arrives mid-refresh
        acc_busy  = 1'b1;
        bank_open = 1'b0;
        run_to(6 * IVL);
        chk("R9 drain at grid point", state_code, 1);
        run_to(6 * IVL + IVL + 5);
        chk("R4 long drain held", state_code, 1);
        acc_busy = 1'b0;
        step();
        chk("R5 direct run", state_code, 3);
        run_to(6 * IVL + IVL + 5 + RFC + 1);
        chk("R7 idle after long refresh", state_code, 0);
        step();
        chk("R9 owed refresh starts", state_code, 1);
        step();
        chk("R9 owed refresh runs", state_code, 3);
        run_to(8 * IVL - 1);
        chk("R9 idle before grid", state_code, 0);
        step();
        chk("R9 grid kept without drift", state_code, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule